// File: doc/BRIEF.md
# RS-485 Line Direction Controller

This block works next to a UART transmitter and steers the direction input of an external half-duplex RS-485 line transceiver. When automatic direction control is enabled, it switches the chosen modem pin high as soon as the transmitter starts sending. It keeps that pin high while frames are on the wire. The release begins only once the transmit shift register has emptied completely. From that point it counts a programmable number of bit periods and then drops the pin to hand the line back to the receiver.

The delay counts bit-rate ticks from the baud generator, not system clocks, so one unit of delay always lasts one bit time at whatever rate is programmed. Either of two modem pins can serve as the direction line. The pin that is not selected, and both pins when automatic control is off, simply carry the values software has written.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: During and directly after reset, with automatic control enabled and no transmission, the selected pin is 0 (receive) and the other pin equals its software value.
- R2: When automatic control is enabled and `tx_busy` is high at a clock edge, the selected pin is 1 after that edge and stays 1 while `tx_busy` stays high.
- R3: The turn-around countdown starts only after an edge where `tx_busy` is 0 and `tsr_empty` is 1. Bit ticks seen earlier (while busy, or while the shift register is not yet empty) do not shorten the delay.
- R4: With a delay value N of 1 or more, the selected pin stays 1 through the first N bit ticks of the countdown and goes to 0 on the edge that samples tick N+1. Idle cycles between ticks do not count.
- R5: With a delay value of 0, the selected pin goes to 0 on the edge that samples the first bit tick of the countdown.
- R6: If `tx_busy` rises during the countdown, the selected pin stays 1. The next countdown then restarts from the full delay value.
- R7: `dir_pin_sel` = 0 makes RTS the direction pin, and `dir_pin_sel` = 1 makes DTR the direction pin.
- R8: While automatic control is enabled, the pin that is not selected equals its software value (`rts_sw` or `dtr_sw`) in every cycle.
- R9: While `auto_en` is 0, `rts_o` equals `rts_sw` and `dtr_o` equals `dtr_sw`, and the controller falls back to receive. Enabling it again without a transmission leaves the selected pin at 0.
- R10: The delay value is captured when the countdown starts. Changes to `turn_delay` during a countdown do not alter its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | Enables automatic direction control (multidrop mode) |
| dir_pin_sel | input | 1 | 0 selects RTS, 1 selects DTR as direction pin |
| turn_delay | input | DELAY_W (8) | Turn-around delay in bit periods |
| bit_tick | input | 1 | One-cycle pulse per bit period at the programmed rate |
| tsr_empty | input | 1 | Transmit shift register holds no data |
| tx_busy | input | 1 | A frame is being shifted out |
| rts_sw | input | 1 | Software value of RTS |
| dtr_sw | input | 1 | Software value of DTR |
| rts_o | output | 1 | RTS pin |
| dtr_o | output | 1 | DTR pin |

## Verification
The hardest case to reach is a transmission that restarts partway through a countdown, because only the next release shows whether the count restarted at the full value or resumed. The bench reaches it by releasing the line, issuing part of the ticks, raising `tx_busy` together with a tick, and then timing the whole following countdown tick by tick. The sweep over delay values, tick spacings and both pin choices also changes `turn_delay` while each count is running, which separates the captured delay from the live input.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

   // Direction controller states
   typedef enum logic [1:0] {
      DIR_RX   = 2'd0,   // transceiver in receive
      DIR_TX   = 2'd1,   // frame on the wire, driver enabled
      DIR_TURN = 2'd2    // shift register empty, counting bit periods
   } dir_state_e;

   // Modem pins that may serve as direction line
   localparam int unsigned PIN_CNT = 2;
   localparam int unsigned PIN_RTS = 0;
   localparam int unsigned PIN_DTR = 1;

endpackage

// File: rtl/rs485_turn_timer.sv
module rs485_turn_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_ZERO;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && (cnt_q != CNT_ZERO)) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == CNT_ZERO);

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
   import rs485_dir_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       auto_en_i,
   input  logic       tx_busy_i,
   input  logic       tsr_empty_i,
   input  logic       bit_tick_i,
   input  logic       cnt_zero_i,
   output logic       load_o,
   output logic       dec_o,
   output logic       drive_o,
   output dir_state_e state_o
);

   dir_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      dec_o   = 1'b0;
      if (!auto_en_i) begin
         state_d = DIR_RX;
      end else begin
         unique case (state_q)
            DIR_RX: begin
               if (tx_busy_i) state_d = DIR_TX;
            end
            DIR_TX: begin
               if (!tx_busy_i && tsr_empty_i) begin
                  state_d = DIR_TURN;
                  load_o  = 1'b1;
               end
            end
            DIR_TURN: begin
               if (tx_busy_i) begin
                  state_d = DIR_TX;
               end else if (bit_tick_i) begin
                  if (cnt_zero_i) state_d = DIR_RX;
                  else            dec_o   = 1'b1;
               end
            end
            default: state_d = DIR_RX;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= DIR_RX;
      else        state_q <= state_d;
   end

   assign drive_o = (state_q != DIR_RX);
   assign state_o = state_q;

endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux
   import rs485_dir_pkg::*;
(
   input  logic               auto_en_i,
   input  logic               sel_i,
   input  logic               drive_i,
   input  logic [PIN_CNT-1:0] sw_i,
   output logic [PIN_CNT-1:0] pin_o
);

   localparam int unsigned SEL_W = $clog2(PIN_CNT);

   for (genvar g = 0; g < PIN_CNT; g++) begin : g_pin
      logic owns_dir;
      assign owns_dir  = auto_en_i && (SEL_W'(sel_i) == SEL_W'(g));
      assign pin_o[g]  = owns_dir ? drive_i : sw_i[g];
   end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
   import rs485_dir_pkg::*;
#(
   parameter int unsigned DELAY_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               auto_en,
   input  logic               dir_pin_sel,
   input  logic [DELAY_W-1:0] turn_delay,
   input  logic               bit_tick,
   input  logic               tsr_empty,
   input  logic               tx_busy,
   input  logic               rts_sw,
   input  logic               dtr_sw,
   output logic               rts_o,
   output logic               dtr_o
);

   if (DELAY_W < 1 || DELAY_W > 16) begin : g_bad_width
      $error("rs485_dir_ctrl: DELAY_W must lie in 1..16");
   end

   dir_state_e         state_q;
   logic               tmr_load;
   logic               tmr_dec;
   logic               tmr_zero;
   logic [DELAY_W-1:0] cnt_q;
   logic               drive;
   logic [PIN_CNT-1:0] sw_vec;
   logic [PIN_CNT-1:0] pin_vec;

   rs485_dir_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_en_i   (auto_en),
      .tx_busy_i   (tx_busy),
      .tsr_empty_i (tsr_empty),
      .bit_tick_i  (bit_tick),
      .cnt_zero_i  (tmr_zero),
      .load_o      (tmr_load),
      .dec_o       (tmr_dec),
      .drive_o     (drive),
      .state_o     (state_q)
   );

   rs485_turn_timer #(.CNT_W(DELAY_W)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (turn_delay),
      .dec_i      (tmr_dec),
      .cnt_o      (cnt_q),
      .zero_o     (tmr_zero)
   );

   assign sw_vec[PIN_RTS] = rts_sw;
   assign sw_vec[PIN_DTR] = dtr_sw;

   rs485_pin_mux i_mux (
      .auto_en_i (auto_en),
      .sel_i     (dir_pin_sel),
      .drive_i   (drive),
      .sw_i      (sw_vec),
      .pin_o     (pin_vec)
   );

   assign rts_o = pin_vec[PIN_RTS];
   assign dtr_o = pin_vec[PIN_DTR];

endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk
   import rs485_dir_pkg::*;
#(
   parameter int unsigned DELAY_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               auto_en,
   input logic               dir_pin_sel,
   input logic [DELAY_W-1:0] turn_delay,
   input logic               bit_tick,
   input logic               tx_busy,
   input logic               rts_sw,
   input logic               dtr_sw,
   input logic               rts_o,
   input logic               dtr_o,
   input dir_state_e         state_q,
   input logic [DELAY_W-1:0] cnt_q,
   input logic               tmr_load
);

   logic sel_pin;
   assign sel_pin = dir_pin_sel ? dtr_o : rts_o;

   a_r2_drive_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && tx_busy) |=> (!auto_en || sel_pin));

   a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && $past(auto_en) && (dir_pin_sel == $past(dir_pin_sel))
       && $past(sel_pin) && !sel_pin)
      |-> ($past(bit_tick) && !$past(tx_busy)));

   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && state_q == DIR_TURN && bit_tick && !tx_busy && cnt_q != '0)
      |=> (cnt_q == DELAY_W'($past(cnt_q) - DELAY_W'(1))));

   a_r6_busy_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && state_q == DIR_TURN && tx_busy) |=> (!auto_en || state_q == DIR_TX));

   a_r8_other_pin: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en |-> (dir_pin_sel ? (rts_o == rts_sw) : (dtr_o == dtr_sw)));

   a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |-> (rts_o == rts_sw && dtr_o == dtr_sw));

   a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_load |=> (cnt_q == $past(turn_delay)));

endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.DELAY_W(DELAY_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .auto_en     (auto_en),
   .dir_pin_sel (dir_pin_sel),
   .turn_delay  (turn_delay),
   .bit_tick    (bit_tick),
   .tx_busy     (tx_busy),
   .rts_sw      (rts_sw),
   .dtr_sw      (dtr_sw),
   .rts_o       (rts_o),
   .dtr_o       (dtr_o),
   .state_q     (state_q),
   .cnt_q       (cnt_q),
   .tmr_load    (tmr_load)
);

// File: tb/test_rs485_dir_ctrl.sv
module test_rs485_dir_ctrl;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       auto_en;
   logic       dir_pin_sel;
   logic [7:0] turn_delay;
   logic       bit_tick;
   logic       tsr_empty;
   logic       tx_busy;
   logic       rts_sw;
   logic       dtr_sw;
   logic       rts_o;
   logic       dtr_o;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rs485_dir_ctrl i_rs485_dir_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_en     (auto_en),
      .dir_pin_sel (dir_pin_sel),
      .turn_delay  (turn_delay),
      .bit_tick    (bit_tick),
      .tsr_empty   (tsr_empty),
      .tx_busy     (tx_busy),
      .rts_sw      (rts_sw),
      .dtr_sw      (dtr_sw),
      .rts_o       (rts_o),
      .dtr_o       (dtr_o)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic sel_pin();
      return dir_pin_sel ? dtr_o : rts_o;
   endfunction

   function automatic logic other_pin();
      return dir_pin_sel ? rts_o : dtr_o;
   endfunction

   function automatic logic other_sw();
      return dir_pin_sel ? rts_sw : dtr_sw;
   endfunction

   // Send a frame, then release it, stepping the countdown tick by tick.
   task automatic run_frame(input int d, input bit sel, input int sp);
      auto_en = 1'b1; dir_pin_sel = sel; turn_delay = 8'(d);
      tx_busy = 1'b1; tsr_empty = 1'b0; bit_tick = 1'b0;
      step();
      chk("R2 pin high on busy", sel_pin(), 1'b1);
      chk("R7 chosen pin", sel ? dtr_o : rts_o, 1'b1);
      chk("R8 other pin", other_pin(), other_sw());
      bit_tick = 1'b1;
      step(); step();
      chk("R3 ticks while busy", sel_pin(), 1'b1);
      tx_busy = 1'b0;
      step(); step();
      chk("R3 ticks before empty", sel_pin(), 1'b1);
      tsr_empty = 1'b1; bit_tick = 1'b0;
      step();
      chk("R4 countdown entered", sel_pin(), 1'b1);
      turn_delay = 8'(d + 5);   // R10: live change must not matter
      rts_sw = ~rts_sw; dtr_sw = ~dtr_sw;
      for (int k = 1; k <= d + 1; k++) begin
         for (int j = 1; j < sp; j++) begin
            bit_tick = 1'b0;
            step();
            chk("R4 idle cycle", sel_pin(), 1'b1);
         end
         bit_tick = 1'b1;
         step();
         if (k == d + 1)
            chk(d == 0 ? "R5 zero delay release" : "R10 R4 release", sel_pin(), 1'b0);
         else
            chk("R4 held before final tick", sel_pin(), 1'b1);
         chk("R8 other pin", other_pin(), other_sw());
      end
      bit_tick = 1'b0;
      step();
      chk("R4 stays receive", sel_pin(), 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n = 1'b0; auto_en = 1'b1; dir_pin_sel = 1'b0; turn_delay = 8'd4;
      bit_tick = 1'b0; tsr_empty = 1'b1; tx_busy = 1'b0;
      rts_sw = 1'b1; dtr_sw = 1'b1;
      step(); step();
      chk("R1 reset rts", rts_o, 1'b0);
      chk("R1 reset dtr sw", dtr_o, 1'b1);
      rst_n = 1'b1;
      step();
      chk("R1 after reset rts", rts_o, 1'b0);
      chk("R1 after reset dtr sw", dtr_o, 1'b1);

      // Sweep delays, tick spacing and pin choice
      for (int s = 0; s < 2; s++) begin
         for (int sp = 1; sp <= 3; sp++) begin
            for (int d = 0; d <= 13; d++) begin
               run_frame((d == 13) ? 255 : d, s[0], sp);
            end
         end
      end

      // R6: new transmission during countdown
      auto_en = 1'b1; dir_pin_sel = 1'b1; turn_delay = 8'd3;
      tx_busy = 1'b1; tsr_empty = 1'b0; bit_tick = 1'b0;
      step();
      tx_busy = 1'b0; tsr_empty = 1'b1;
      step();
      bit_tick = 1'b1;
      step(); step();
      chk("R6 mid countdown", dtr_o, 1'b1);
      tx_busy = 1'b1; tsr_empty = 1'b0;
      step();
      chk("R6 abort keeps transmit", dtr_o, 1'b1);
      step(); step();
      chk("R6 busy again", dtr_o, 1'b1);
      tx_busy = 1'b0; tsr_empty = 1'b1; bit_tick = 1'b0;
      step();
      bit_tick = 1'b1;
      step(); step(); step();
      chk("R6 full delay restart", dtr_o, 1'b1);
      step();
      chk("R6 release after restart", dtr_o, 1'b0);
      bit_tick = 1'b0;

      // R9: disable during countdown
      turn_delay = 8'd9;
      tx_busy = 1'b1; tsr_empty = 1'b0;
      step();
      tx_busy = 1'b0; tsr_empty = 1'b1;
      step();
      bit_tick = 1'b1;
      step();
      auto_en = 1'b0; rts_sw = 1'b1; dtr_sw = 1'b0;
      step();
      chk("R9 bypass rts", rts_o, 1'b1);
      chk("R9 bypass dtr", dtr_o, 1'b0);
      rts_sw = 1'b0; dtr_sw = 1'b1;
      step();
      chk("R9 bypass rts follow", rts_o, 1'b0);
      chk("R9 bypass dtr follow", dtr_o, 1'b1);
      auto_en = 1'b1; bit_tick = 1'b0;
      step();
      chk("R9 back in receive", dtr_o, 1'b0);
      chk("R8 rts software", rts_o, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule